// File: doc/BRIEF.md
# Synchronous Serial Transmitter with Data-Pin Tristate Timing

This block shifts one parallel word, 4 to 32 bits long, out of a serial data pin MSB first. It always generates the serial clock. It can either generate the frame strobe itself (frame master) or wait for a frame strobe from outside (frame follower). A separate output enable for the data pin tells the pad when to drive and when to float. When tristating is enabled, the enable rises and falls on exact internal edge counts, and those counts depend on the frame role.

All timing is counted in internal half-bit edges. Edges are numbered k = 0, 1, 2, ... from the start of a word and are spaced `HALF_DIV` core clocks apart. Even edges drive data, and odd edges are the receiver's sampling points. A word of N bits uses edges 0 through 2N. The edge counter keeps running up to edge 2N even when the serial clock pin has already stopped toggling.

A word is loaded through a valid/ready handshake. The configuration inputs must be held steady from the accepting clock until the handshake is ready again.

Top module: `sertx_tri`

## Requirements
- R1: `cfg_len` holds the word length minus one. Codes below 3 are treated as 3, so the word is 4 bits. Bit N-1-i of `in_data` (MSB first) appears on `txd_o` after edge 2i. Bits above N-1 are ignored.
- R2: In the frame-master role, edge k is processed on rising clock A+1+k·HALF_DIV, where A is the clock on which the word was accepted.
- R3: `cfg_mode[1]` is the idle level of `sclk_o`. With `cfg_mode[0]`=0 the pin toggles on edges 1..2N. With `cfg_mode[0]`=1 it toggles on edges 0..2N-1. It therefore ends each word at its idle level.
- R4: With `cfg_tte`=0, `txd_oe_o` stays 1 at all times.
- R5: With `cfg_tte`=1, `txd_oe_o` rises on edge 0, the same edge that drives the MSB.
- R6: In the frame-follower role (`cfg_slave`=1) with `cfg_tte`=1, `txd_oe_o` falls on edge 2N-1, the edge after the one that starts the LSB.
- R7: In the frame-master role with `cfg_tte`=1, `txd_oe_o` falls on edge 2N, two edges after the LSB drive edge. This holds even when `cfg_mode[0]`=1 and that edge produces no `sclk_o` toggle.
- R8: `cfg_fpol`=1 makes the frame active high and 0 makes it active low. As frame master, `frm_o` is active from edge 0 and inactive from edge 2N. As frame follower, `frm_o` stays at its inactive level.
- R9: As frame follower, an accepted word waits with the data pin released. `frm_i` is synchronised through two flops. Edge 0 is processed on the fourth rising clock after `frm_i` turns active.
- R10: `in_ready` is 1 only when no word is being shifted or waiting. It is 0 after an accept and returns to 1 once edge 2N has been processed.
- R11: Between words, `txd_o` holds the last bit sent. With `cfg_tte`=1, `txd_oe_o` is 0.
- R12: After reset, `in_ready`=1, `txd_o`=0, `sclk_o` is at its idle level, `frm_o` is inactive and `txd_oe_o`=`!cfg_tte`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Bit 1: clock idle level; bit 0: clock phase |
| cfg_fpol | input | 1 | Frame polarity, 1 = active high |
| cfg_tte | input | 1 | Enable data-pin tristating between words |
| cfg_slave | input | 1 | 1 = follow `frm_i`, 0 = generate `frm_o` |
| cfg_len | input | 5 | Word length minus one |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Word can be accepted |
| in_data | input | 32 | Word to send, right aligned |
| frm_i | input | 1 | External frame strobe (follower role) |
| sclk_o | output | 1 | Serial clock pin |
| frm_o | output | 1 | Frame strobe pin (master role) |
| txd_o | output | 1 | Serial data pin value |
| txd_oe_o | output | 1 | Serial data pin output enable |

## Verification
Every result is due on a known clock, so the bench computes the expected values per cycle.

- **Frame master:** edge k lands HALF_DIV·k+1 clocks after the accepting edge.
- **Frame follower:** edge k lands HALF_DIV·k+4 clocks after `frm_i` changes, because of the two synchroniser flops, the detect flop and the start flop.

After every rising clock, the bench derives the index of the latest processed edge from the elapsed cycle count. From that index it computes the data bit, the clock level, the frame level, the output enable and `in_ready`, and it samples all five on the falling clock. This places the release of the enable at 2N-1 or 2N exactly, and never one cycle early or late.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

   // Smallest and largest word length the shifter supports
   localparam int WORD_MIN = 4;
   localparam int WORD_MAX = 32;

   // Minimum synchroniser depth for the external frame strobe
   localparam int SYNC_MIN = 2;

   // Role and phase decoded from the configuration pins
   typedef struct packed {
      logic cpol;    // idle level of the serial clock
      logic cpha;    // 1: clock toggles on the drive edge of each bit
      logic tte;     // tristate data pin between words
      logic slave;   // follow the external frame strobe
   } sertx_mode_t;

   // Width of an edge index able to hold 2*bits
   function automatic int edge_width(input int bits);
      return $clog2(2 * bits + 1);
   endfunction

endpackage

// File: rtl/sertx_tick.sv
module sertx_tick #(
   parameter int HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   if (HALF_DIV < 1) begin : g_bad_div
      $error("sertx_tick: HALF_DIV must be at least 1");
   end

   if (HALF_DIV == 1) begin : g_every
      logic run_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) run_q <= 1'b0;
         else        run_q <= run;
      end
      assign tick = run & (run_q | run);
   end else begin : g_count
      localparam int CW = $clog2(HALF_DIV);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            cnt <= '0;
         else if (!run)         cnt <= '0;
         else if (cnt == '0)    cnt <= CW'(HALF_DIV - 1);
         else                   cnt <= cnt - 1'b1;
      end
      assign tick = run && (cnt == '0);
   end

endmodule

// File: rtl/sertx_fsync.sv
module sertx_fsync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fpol,
   input  logic frm_i,
   output logic rise
);
   import sertx_pkg::*;

   if (STAGES < SYNC_MIN) begin : g_bad_sync
      $error("sertx_fsync: STAGES below minimum");
   end

   logic [STAGES-1:0] sq;
   logic              act;
   logic              act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sq <= '0;
      else        sq <= {sq[STAGES-2:0], frm_i};
   end

   assign act = fpol ? sq[STAGES-1] : ~sq[STAGES-1];

   // Reset to "already active" so a reset level never looks like a new frame
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_q <= 1'b1;
      else        act_q <= act;
   end

   assign rise = act & ~act_q;

endmodule

// File: rtl/sertx_seq.sv
module sertx_seq #(
   parameter int MAX_BITS = 32,
   parameter int EW       = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                tick,
   input  sertx_pkg::sertx_mode_t mode,
   input  logic [EW-1:0]       last_edge,
   input  logic [MAX_BITS-1:0] word_al,
   output logic                busy,
   output logic                txd,
   output logic                oe,
   output logic                tog,
   output logic                frm_on
);

   logic [EW-1:0]       ecnt;
   logic [MAX_BITS-1:0] sh;
   logic [EW-1:0]       rel_edge;
   logic                drive_edge;
   logic                clk_edge;

   // Follower releases one edge after the LSB starts, master two edges after
   assign rel_edge   = mode.slave ? (last_edge - 1'b1) : last_edge;
   assign drive_edge = !ecnt[0] && (ecnt != last_edge);
   assign clk_edge   = mode.cpha ? (ecnt != last_edge) : (ecnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         ecnt   <= '0;
         sh     <= '0;
         txd    <= 1'b0;
         oe     <= 1'b0;
         tog    <= 1'b0;
         frm_on <= 1'b0;
      end else if (start) begin
         busy <= 1'b1;
         ecnt <= '0;
         sh   <= word_al;
         tog  <= 1'b0;
      end else if (busy && tick) begin
         if (drive_edge) begin
            txd <= sh[MAX_BITS-1];
            sh  <= sh << 1;
         end
         if (ecnt == '0)            oe <= 1'b1;
         else if (ecnt == rel_edge) oe <= 1'b0;
         if (clk_edge) tog <= ~tog;
         if (ecnt == '0)             frm_on <= !mode.slave;
         else if (ecnt == last_edge) frm_on <= 1'b0;
         if (ecnt == last_edge) busy <= 1'b0;
         else                   ecnt <= ecnt + 1'b1;
      end
   end

endmodule

// File: rtl/sertx_tri.sv
module sertx_tri #(
   parameter int MAX_BITS    = 32,
   parameter int HALF_DIV    = 2,
   parameter int SYNC_STAGES = 2,
   localparam int LW = $clog2(MAX_BITS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          cfg_mode,
   input  logic                cfg_fpol,
   input  logic                cfg_tte,
   input  logic                cfg_slave,
   input  logic [LW-1:0]       cfg_len,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [MAX_BITS-1:0] in_data,
   input  logic                frm_i,
   output logic                sclk_o,
   output logic                frm_o,
   output logic                txd_o,
   output logic                txd_oe_o
);
   import sertx_pkg::*;

   localparam int EW = edge_width(MAX_BITS);

   if (MAX_BITS < WORD_MIN || MAX_BITS > WORD_MAX) begin : g_bad_bits
      $error("sertx_tri: MAX_BITS out of range");
   end

   sertx_mode_t         mode;
   logic                busy;
   logic                loaded;
   logic [MAX_BITS-1:0] hold;
   logic                accept;
   logic                frm_rise;
   logic                start;
   logic                tick;
   logic [LW-1:0]       len_c;
   logic [EW-1:0]       nbits;
   logic [EW-1:0]       last_edge;
   logic [MAX_BITS-1:0] word_sel;
   logic [MAX_BITS-1:0] word_al;
   logic                txd_q;
   logic                oe_q;
   logic                tog;
   logic                frm_on;

   assign mode = '{cpol: cfg_mode[1], cpha: cfg_mode[0],
                   tte: cfg_tte, slave: cfg_slave};

   // Length clamp: at least WORD_MIN bits, at most MAX_BITS
   always_comb begin
      len_c = cfg_len;
      if (cfg_len < LW'(WORD_MIN - 1))     len_c = LW'(WORD_MIN - 1);
      else if (cfg_len > LW'(MAX_BITS - 1)) len_c = LW'(MAX_BITS - 1);
   end

   assign nbits     = EW'(len_c) + 1'b1;
   assign last_edge = nbits << 1;

   // Handshake and follower-role holding register
   assign in_ready = !busy && !loaded;
   assign accept   = in_valid && in_ready;
   assign start    = (accept && !cfg_slave) || (loaded && frm_rise && !busy);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loaded <= 1'b0;
         hold   <= '0;
      end else if (accept && cfg_slave) begin
         loaded <= 1'b1;
         hold   <= in_data;
      end else if (start) begin
         loaded <= 1'b0;
      end
   end

   assign word_sel = loaded ? hold : in_data;
   assign word_al  = word_sel << (EW'(MAX_BITS) - nbits);

   sertx_fsync #(.STAGES(SYNC_STAGES)) u_fsync (
      .clk   (clk),
      .rst_n (rst_n),
      .fpol  (cfg_fpol),
      .frm_i (frm_i),
      .rise  (frm_rise)
   );

   sertx_tick #(.HALF_DIV(HALF_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy),
      .tick  (tick)
   );

   sertx_seq #(.MAX_BITS(MAX_BITS), .EW(EW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .tick      (tick),
      .mode      (mode),
      .last_edge (last_edge),
      .word_al   (word_al),
      .busy      (busy),
      .txd       (txd_q),
      .oe        (oe_q),
      .tog       (tog),
      .frm_on    (frm_on)
   );

   assign sclk_o   = mode.cpol ^ tog;
   assign frm_o    = frm_on ^ ~cfg_fpol;
   assign txd_o    = txd_q;
   assign txd_oe_o = mode.tte ? oe_q : 1'b1;

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] cfg_mode,
   input logic       cfg_fpol,
   input logic       cfg_tte,
   input logic       in_valid,
   input logic       in_ready,
   input logic       sclk_o,
   input logic       frm_o,
   input logic       txd_o,
   input logic       txd_oe_o
);

   AST_READY_PIN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_tte && in_ready) |-> !txd_oe_o);                          // R11

   AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);                         // R10

   AST_IDLE_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && $past(in_ready)) |-> $stable(txd_o));             // R11

   AST_IDLE_CLOCK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> (sclk_o == cfg_mode[1]));                         // R3

   AST_IDLE_FRAME_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> (frm_o == !cfg_fpol));                            // R8

   AST_ENABLE_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_tte && $rose(txd_oe_o)) |-> !in_ready);                   // R5

endmodule

bind sertx_tri sertx_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_mode (cfg_mode),
   .cfg_fpol (cfg_fpol),
   .cfg_tte  (cfg_tte),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .sclk_o   (sclk_o),
   .frm_o    (frm_o),
   .txd_o    (txd_o),
   .txd_oe_o (txd_oe_o)
);

// File: tb/sim_sertx_tri.sv
`timescale 1ns/1ps
module sim_sertx_tri;

   localparam int H = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_mode = 2'd0;
   logic        cfg_fpol = 1'b1;
   logic        cfg_tte = 1'b1;
   logic        cfg_slave = 1'b0;
   logic [4:0]  cfg_len = 5'd7;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_data = '0;
   logic        frm_i = 1'b0;
   logic        sclk_o, frm_o, txd_o, txd_oe_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   sertx_tri #(.MAX_BITS(32), .HALF_DIV(H), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_fpol(cfg_fpol),
      .cfg_tte(cfg_tte), .cfg_slave(cfg_slave), .cfg_len(cfg_len),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .frm_i(frm_i), .sclk_o(sclk_o), .frm_o(frm_o), .txd_o(txd_o),
      .txd_oe_o(txd_oe_o)
   );

   task automatic chk(input string rq, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b t=%0t", rq, act, exp, $time);
      end
   endtask

   task automatic xfer(input logic [1:0] mode, input bit slave, input bit tte,
                       input bit fpol, input logic [4:0] lcode, input logic [31:0] word);
      int n = (lcode < 5'd3) ? 4 : int'(lcode) + 1;
      @(negedge clk);
      cfg_mode = mode; cfg_slave = slave; cfg_tte = tte; cfg_fpol = fpol;
      cfg_len = lcode; frm_i = !fpol;
      repeat (4) @(negedge clk);
      chk("R10 idle ready", in_ready, 1'b1);
      chk("R3 idle clock", sclk_o, mode[1]);
      chk("R8 idle frame", frm_o, !fpol);
      if (tte) chk("R11 idle released", txd_oe_o, 1'b0);
      else     chk("R4 idle driven", txd_oe_o, 1'b1);
      in_data = word; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R10 ready after accept", in_ready, 1'b0);
      if (slave) begin
         frm_i = fpol;
         for (int w = 0; w < 3; w++) begin
            @(negedge clk);
            chk("R9 word waits", txd_oe_o, !tte);
         end
      end
      for (int t = 0; t <= 2*n*H + 1; t++) begin
         int e, bi, tc, rel;
         @(negedge clk);
         e  = t / H;
         if (e > 2*n) e = 2*n;
         bi = (e / 2 > n - 1) ? n - 1 : e / 2;
         chk("R1 R2 data bit", txd_o, word[n-1-bi]);
         tc = mode[0] ? ((e + 1 > 2*n) ? 2*n : e + 1) : e;
         chk("R3 clock level", sclk_o, mode[1] ^ tc[0]);
         rel = slave ? 2*n - 1 : 2*n;
         if (!tte)       chk("R4 enable held", txd_oe_o, 1'b1);
         else if (e == 0) chk("R5 enable with MSB", txd_oe_o, 1'b1);
         else if (slave) chk("R6 follower release", txd_oe_o, e < rel);
         else            chk("R7 master release", txd_oe_o, e < rel);
         if (slave) chk("R8 follower frame", frm_o, !fpol);
         else       chk("R8 master frame", frm_o, (e < 2*n) ? fpol : !fpol);
         chk("R10 ready at end", in_ready, e == 2*n);
      end
      frm_i = !fpol;
      repeat (3) @(negedge clk);
      chk("R11 data held", txd_o, word[0]);
      chk("R11 enable idle", txd_oe_o, !tte);
   endtask

   initial begin
      logic [4:0] codes [4];
      logic [31:0] w;
      int idx = 0;
      codes[0] = 5'd0; codes[1] = 5'd6; codes[2] = 5'd15; codes[3] = 5'd31;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 reset ready", in_ready, 1'b1);
      chk("R12 reset data", txd_o, 1'b0);
      chk("R12 reset clock", sclk_o, 1'b0);
      chk("R12 reset frame", frm_o, 1'b0);
      chk("R12 reset enable", txd_oe_o, 1'b0);
      for (int m = 0; m < 4; m++)
         for (int s = 0; s < 2; s++)
            for (int te = 0; te < 2; te++)
               for (int p = 0; p < 2; p++)
                  for (int l = 0; l < 4; l++) begin
                     w = 32'hA5C3_96E1 ^ (32'(idx) * 32'h9E37_79B9);
                     idx++;
                     xfer(2'(m), s[0], te[0], p[0], codes[l], w);
                  end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog R10 actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule